// File: doc/BRIEF.md
# Clock-Sampled Asynchronous SRAM Emulator

This block stands in for a one-bit-wide asynchronous static RAM when a memory controller is being tested inside a clocked design. A fast clock samples the active-low chip select, the active-low write enable, the address and the single data-in bit. From these samples the block works out whether the device is idle, being read or being written. It has one data-out bit, plus a flag that says whether that bit would be driven or left floating. The depth is set by an address-width parameter. A width of 16 gives the full 65,536-location part. The default is smaller so that elaboration stays cheap.

A write does not happen on a particular clock edge. It is committed at the sample where the overlap of low chip select and low write enable ends. The stored bit is the data-in value from the last sample inside the overlap, and it goes to the address seen at the first sample of the overlap. If chip select falls in the same sample as write enable, or later, the output stays floating until chip select goes high again. A sticky flag records any address change made while the overlap is active. Only the reset clears it.

Top module: `sram_emu`

## Requirements
- R1: The block stores 2^ADDR_W one-bit words. Data in and data out are separate ports, and a read returns the last bit committed to that address.
- R2: While cs_n is sampled high (idle), oe is 0 and no location changes, even when we_n is low.
- R3: Whenever oe is 0, dout is 0.
- R4: While cs_n and we_n are both sampled low (write), oe is 0.
- R5: A write is committed only once a run of samples with cs_n and we_n both low has ended. It goes to the address sampled at the first sample of that run.
- R6: The stored bit is the din of the last sample in the overlap. din changes earlier in the overlap, or at the sample that ends it, have no effect.
- R7: If the overlap begins at a sample where cs_n has just gone low (cs_n falls in the same sample as we_n, or after it), oe stays 0 until cs_n is sampled high. This holds even if we_n rises while cs_n is still low.
- R8: If cs_n was already low when we_n fell, then once we_n rises with cs_n still low, oe returns to 1 and dout carries the newly written bit.
- R9: oe and dout reflect a stable read request at the second rising clock edge after the inputs are first presented: one input-sampling register, then one output register.
- R10: viol becomes 1 when the address differs between two consecutive samples that both have cs_n and we_n low. It then stays 1 until reset.
- R11: While reset is asserted, and until two clock edges after it is released, oe, dout and viol are 0. Storage contents are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the emulated access time |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| din | input | 1 | Data bit to be written |
| dout | output | 1 | Data bit read; 0 when not driven |
| oe | output | 1 | 1 when dout would be driven, 0 for the floating state |
| viol | output | 1 | Sticky flag: address moved during a write overlap |

## Verification
The assertions check several rules on every cycle, whatever the stimulus. The output floats in idle and in write mode, dout is quiet whenever oe is low, a commit always follows a sampled overlap, and the violation flag never falls outside reset. The bench scenarios cover the rest:

- the storage contents themselves,
- which din sample becomes the stored bit,
- the address captured at overlap start,
- the late chip-select hold of the floating output,
- the return to driving after a write controlled by write enable,
- the two-edge read latency.

It checks these through a reference model, mixing random writes and reads with directed sequences.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } sram_mode_e;

  function automatic sram_mode_e decode_mode(input logic cs_n_s, input logic we_n_s);
    if (cs_n_s)      return MODE_IDLE;
    else if (we_n_s) return MODE_READ;
    else             return MODE_WRITE;
  endfunction

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic              commit_data,
  output logic              addr_moved
);

  // input sampling stage
  logic              cs_n_s, we_n_s, din_s;
  logic [ADDR_W-1:0] addr_s;
  // history of the sampling stage
  logic              cs_n_h, ovl_h;
  logic [ADDR_W-1:0] addr_h;
  // write window capture
  logic [ADDR_W-1:0] wr_addr_q;
  logic              wr_data_q;
  logic              float_hold_q;

  sram_mode_e        mode;
  logic              ovl, ovl_start, ovl_end, hold_set;
  logic              float_hold_d;
  logic              wa_en, wd_en;

  always_comb begin
    mode      = decode_mode(cs_n_s, we_n_s);
    ovl       = (mode == MODE_WRITE);
    ovl_start = ovl & ~ovl_h;
    ovl_end   = ovl_h & ~ovl;
    hold_set  = ovl_start & cs_n_h;
    wa_en     = ovl_start;
    wd_en     = ovl;
    if (cs_n_s)        float_hold_d = 1'b0;
    else if (hold_set) float_hold_d = 1'b1;
    else               float_hold_d = float_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_s <= 1'b1;
      we_n_s <= 1'b1;
      addr_s <= '0;
      din_s  <= 1'b0;
      cs_n_h <= 1'b1;
      ovl_h  <= 1'b0;
      addr_h <= '0;
      float_hold_q <= 1'b0;
    end else begin
      cs_n_s <= cs_n;
      we_n_s <= we_n;
      addr_s <= addr;
      din_s  <= din;
      cs_n_h <= cs_n_s;
      ovl_h  <= ovl;
      addr_h <= addr_s;
      float_hold_q <= float_hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= 1'b0;
    end else begin
      if (wa_en) wr_addr_q <= addr_s;
      if (wd_en) wr_data_q <= din_s;
    end
  end

  assign rd_addr     = addr_s;
  assign rd_en       = (mode == MODE_READ) & ~float_hold_q;
  assign commit      = ovl_end;
  assign commit_addr = wr_addr_q;
  assign commit_data = wr_data_q;
  assign addr_moved  = ovl & ovl_h & (addr_s != addr_h);

  AST_COMMIT_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(cs_n_s) == 1'b0 && $past(we_n_s) == 1'b0)); // R5

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  output logic              rd_valid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];
  logic rd_bit_d;

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bit;
  end

  always_comb begin
    rd_bit_d = rd_en ? mem[rd_addr] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bit   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_bit   <= rd_bit_d;
      rd_valid <= rd_en;
    end
  end

endmodule

// File: rtl/sram_emu_viol.sv
module sram_emu_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic moved,
  output logic flag
);

  logic flag_d;

  always_comb begin
    flag_d = flag | moved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag) |-> flag); // R10

endmodule

// File: rtl/sram_emu.sv
module sram_emu #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              oe,
  output logic              viol
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [ADDR_W-1:0]      rd_addr, commit_addr;
  logic                   rd_en, commit, commit_data, addr_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  sram_emu_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_n        (cs_n),
    .we_n        (we_n),
    .addr        (addr),
    .din         (din),
    .rd_addr     (rd_addr),
    .rd_en       (rd_en),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .addr_moved  (addr_moved)
  );

  sram_emu_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (commit),
    .wr_addr  (commit_addr),
    .wr_bit   (commit_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_bit   (dout),
    .rd_valid (oe)
  );

  sram_emu_viol u_viol (
    .clk   (clk),
    .rst_n (rst_int_n),
    .moved (addr_moved),
    .flag  (viol)
  );

  AST_IDLE_FLOATS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(cs_n, 2) |-> !oe); // R2

  AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(cs_n, 2) && !$past(we_n, 2)) |-> !oe); // R4

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !oe |-> !dout); // R3

endmodule

// File: tb/tb_sram_emu.sv
module tb_sram_emu;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, we_n, din;
  logic [AW-1:0] addr;
  logic          dout, oe, viol;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic model [DEPTH];
  logic known [DEPTH];

  always #5 clk = ~clk;

  sram_emu #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .oe(oe), .viol(viol)
  );

  function automatic logic exp_bit(input logic [AW-1:0] a);
    return model[a];
  endfunction

  function automatic logic exp_dout(input logic en, input logic b);
    return en ? b : 1'b0;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic [AW-1:0] a, input logic d);
    cs_n = c; we_n = w; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, addr, 1'b0);
  endtask

  // chip-select controlled write: we_n falls first, cs_n falls later
  task automatic write_cs(input logic [AW-1:0] a, input logic d);
    step(1'b1, 1'b0, a, ~d);
    step(1'b0, 1'b0, a, ~d);
    step(1'b0, 1'b0, a, d);
    step(1'b1, 1'b0, a, ~d);
    idle(2);
    model[a] = d; known[a] = 1'b1;
  endtask

  // write-enable controlled write: cs_n already low
  task automatic write_we(input logic [AW-1:0] a, input logic d);
    step(1'b0, 1'b1, a, ~d);
    step(1'b0, 1'b0, a, d);
    step(1'b0, 1'b1, a, ~d);
    idle(2);
    model[a] = d; known[a] = 1'b1;
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a);
    step(1'b0, 1'b1, a, 1'b0);
    step(1'b0, 1'b1, a, 1'b0);
    check(req, "read oe", oe, 1'b1);
    check(req, "read dout", dout, exp_dout(1'b1, exp_bit(a)));
    idle(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin model[i] = 1'b0; known[i] = 1'b0; end
    void'($urandom(32'h5A17_C0DE));
    cs_n = 1'b1; we_n = 1'b1; addr = '0; din = 1'b0; rst_n = 1'b0;
    @(negedge clk);

    // R11: outputs during and after reset
    idle(2);
    check("R11", "oe in reset", oe, 1'b0);
    check("R11", "viol in reset", viol, 1'b0);
    rst_n = 1'b1;
    idle(3);
    check("R11", "oe after reset", oe, 1'b0);
    check("R11", "dout after reset", dout, 1'b0);
    check("R11", "viol after reset", viol, 1'b0);

    // R1 R5: basic write/read both polarities
    write_cs(10'h005, 1'b1);
    write_cs(10'h006, 1'b0);
    read_chk("R1", 10'h005);
    read_chk("R5", 10'h006);

    // R9: two-edge latency of a read request
    step(1'b0, 1'b1, 10'h005, 1'b0);
    check("R9", "oe after one edge", oe, 1'b0);
    step(1'b0, 1'b1, 10'h005, 1'b0);
    check("R9", "oe after two edges", oe, 1'b1);
    check("R9", "dout after two edges", dout, 1'b1);
    idle(1);

    // R2: idle with we_n low must not write; R3 dout quiet
    step(1'b1, 1'b0, 10'h005, 1'b0);
    step(1'b1, 1'b0, 10'h005, 1'b0);
    step(1'b1, 1'b0, 10'h005, 1'b0);
    check("R2", "oe idle", oe, 1'b0);
    check("R3", "dout while floating", dout, 1'b0);
    idle(2);
    read_chk("R2", 10'h005);

    // R4: write mode floats
    step(1'b0, 1'b1, 10'h020, 1'b1);
    step(1'b0, 1'b0, 10'h020, 1'b1);
    step(1'b0, 1'b0, 10'h020, 1'b1);
    check("R4", "oe during write", oe, 1'b0);
    check("R3", "dout during write", dout, 1'b0);
    // R8: we_n rises, cs_n stays low: drives new bit
    step(1'b0, 1'b1, 10'h020, 1'b0);
    step(1'b0, 1'b1, 10'h020, 1'b0);
    step(1'b0, 1'b1, 10'h020, 1'b0);
    model[10'h020] = 1'b1; known[10'h020] = 1'b1;
    check("R8", "oe after we-controlled write", oe, 1'b1);
    check("R8", "dout after we-controlled write", dout, 1'b1);
    idle(2);

    // R7: cs_n falls with we_n low already; we_n rises while cs_n low
    step(1'b1, 1'b0, 10'h030, 1'b1);
    step(1'b0, 1'b0, 10'h030, 1'b1);
    step(1'b0, 1'b1, 10'h030, 1'b0);
    step(1'b0, 1'b1, 10'h030, 1'b0);
    step(1'b0, 1'b1, 10'h030, 1'b0);
    check("R7", "oe held floating", oe, 1'b0);
    model[10'h030] = 1'b1; known[10'h030] = 1'b1;
    idle(2);
    read_chk("R7", 10'h030);
    // R7: simultaneous fall
    step(1'b0, 1'b0, 10'h031, 1'b1);
    step(1'b0, 1'b1, 10'h031, 1'b0);
    step(1'b0, 1'b1, 10'h031, 1'b0);
    step(1'b0, 1'b1, 10'h031, 1'b0);
    check("R7", "oe held after joint fall", oe, 1'b0);
    model[10'h031] = 1'b1; known[10'h031] = 1'b1;
    idle(2);
    read_chk("R7", 10'h031);

    // R6: last overlap sample wins; ending sample din ignored
    step(1'b0, 1'b1, 10'h040, 1'b0);
    step(1'b0, 1'b0, 10'h040, 1'b1);
    step(1'b0, 1'b0, 10'h040, 1'b1);
    step(1'b0, 1'b0, 10'h040, 1'b0);
    step(1'b1, 1'b1, 10'h040, 1'b1);
    idle(2);
    model[10'h040] = 1'b0; known[10'h040] = 1'b1;
    read_chk("R6", 10'h040);
    check("R10", "no viol yet", viol, 1'b0);

    // R10 R5: address moves inside overlap; commit uses start address
    write_cs(10'h051, 1'b0);
    step(1'b0, 1'b1, 10'h050, 1'b0);
    step(1'b0, 1'b0, 10'h050, 1'b1);
    step(1'b0, 1'b0, 10'h051, 1'b1);
    step(1'b0, 1'b1, 10'h051, 1'b0);
    idle(2);
    model[10'h050] = 1'b1; known[10'h050] = 1'b1;
    check("R10", "viol set", viol, 1'b1);
    read_chk("R5", 10'h050);
    read_chk("R5", 10'h051);
    idle(4);
    check("R10", "viol sticky", viol, 1'b1);
    do_reset();
    check("R10", "viol cleared by reset", viol, 1'b0);
    read_chk("R11", 10'h050);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic          d;
      int            op;
      a  = AW'($urandom % 48);
      if ($urandom % 8 == 0) a = AW'($urandom);
      d  = 1'($urandom);
      op = int'($urandom % 3);
      if (op == 0)            write_cs(a, d);
      else if (op == 1)       write_we(a, d);
      else if (known[a])      read_chk("R1", a);
      else                    write_cs(a, d);
    end
    check("R10", "viol clean after legal traffic", viol, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule